// File: doc/BRIEF.md
# Masked Interrupt Source Selector

This block collects a parameterised number of event sources (eight by default) into one interrupt request line. Each source has a sticky event flag and an enable bit. Both are visible in one control/status word. The enable mask sits in the upper half of the word and the flags sit in the lower half. A flag records its event whether or not the source is enabled, so software can poll events from masked sources. Only enabled sources can raise the shared request.

The handler reads the flag half of the word to find which source fired. It then clears that flag by writing a one to the flag's bit position. A per-half write strobe lets software change the enables without touching the flags, and clear flags without touching the enables. The event inputs carry no state of their own, so the same event wires can feed several selector instances, each with its own mask.

Top module: `irqsel_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_data` reads all zeros and `irq_o` is low.
- R2: If `evt_in[i]` is high at a rising clock edge, flag bit `rd_data[i]` reads 1 after that edge. This holds whatever the value of enable bit i.
- R3: A set flag stays set until a write clears it. A write with `wr_en`=1 and `wr_strb[0]`=1 clears every flag whose bit in `wr_data[N-1:0]` is 1. Flags whose bit in `wr_data[N-1:0]` is 0 are left unchanged.
- R4: If a flag is cleared by a write and its event is high at the same edge, the flag ends up set.
- R5: A write with `wr_en`=1 and `wr_strb[1]`=1 loads the enable mask `rd_data[2N-1:N]` from `wr_data[2N-1:N]`. When `wr_strb[1]`=0 the enable mask is unchanged. When `wr_strb[0]`=0 the flags are not cleared.
- R6: `irq_o` is registered. It goes high one clock edge after the register state first has some bit i with both flag i and enable i set.
- R7: `irq_o` goes low one clock edge after the last source with both its flag and its enable set loses either one, through a flag clear or an enable removal.
- R8: A flag whose enable bit is 0 never causes `irq_o` to be high.
- R9: While `wr_en` is 0, `wr_strb` and `wr_data` have no effect on the enables or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | N | Event inputs, one per source, sampled at each rising edge |
| wr_en | input | 1 | Write cycle qualifier |
| wr_strb | input | 2 | Bit 1 writes the enable half, bit 0 clears flags with write-one-to-clear |
| wr_data | input | 2N | Write data: enables in [2N-1:N], flag clear mask in [N-1:0] |
| rd_data | output | 2N | Status word: enables in [2N-1:N], flags in [N-1:0] |
| irq_o | output | 1 | Registered shared interrupt request |

## Verification
Flags and enables show in `rd_data` after the same edge that samples the event or the write. `irq_o` follows one edge later, because it is computed from those registers. The bench drives inputs on the falling edge and advances a behavioural model on each rising edge. On every falling edge it compares `rd_data` and `irq_o` against the model. Directed checks sample at the first falling edge after the stimulus for register state, and at the second falling edge for the request. These include a check that the request is still low at the first falling edge, which proves it has the one-cycle lag.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  // Strobe lane assignment inside wr_strb
  localparam int unsigned LANE_FLAG = 0;
  localparam int unsigned LANE_EN   = 1;
  localparam int unsigned NUM_LANES = 2;

  typedef enum logic [1:0] {
    WR_NONE  = 2'b00,
    WR_CLEAR = 2'b01,
    WR_MASK  = 2'b10,
    WR_BOTH  = 2'b11
  } wr_kind_e;
endpackage

// File: rtl/irqsel_flag_bank.sv
module irqsel_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    // Event has precedence over a same-cycle clear
    always_ff @(posedge clk) begin
      if (rst)            flag_o[g] <= 1'b0;
      else if (evt_i[g])  flag_o[g] <= 1'b1;
      else if (clr_i[g])  flag_o[g] <= 1'b0;
    end
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_o & $past(evt_i)) == $past(evt_i)));

  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_o & $past(flag_o & ~clr_i)) == $past(flag_o & ~clr_i)));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & clr_i)) |=> ((flag_o & $past(evt_i & clr_i)) == $past(evt_i & clr_i)));
endmodule

// File: rtl/irqsel_enable_reg.sv
module irqsel_enable_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (rst)       en_o <= '0;
    else if (we_i) en_o <= d_i;
  end

  a_r5_mask_holds: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(en_o));

  a_r5_mask_loads: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (en_o == $past(d_i)));
endmodule

// File: rtl/irqsel_req_gen.sv
module irqsel_req_gen #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] live;
  assign live = flag_i & en_i;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |live;
  end

  a_r6_req_rises: assert property (@(posedge clk) disable iff (rst)
    (|(flag_i & en_i)) |=> irq_o);

  a_r7_req_drops: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_i & en_i)) |=> !irq_o);

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (en_i == '0) |=> !irq_o);
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
  import irqsel_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned W = 2 * N
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         evt_in,
  input  logic                 wr_en,
  input  logic [NUM_LANES-1:0] wr_strb,
  input  logic [W-1:0]         wr_data,
  output logic [W-1:0]         rd_data,
  output logic                 irq_o
);
  logic         flag_we;
  logic         en_we;
  logic [N-1:0] clr_mask;
  logic [N-1:0] flags;
  logic [N-1:0] enables;

  assign flag_we  = wr_en & wr_strb[LANE_FLAG];
  assign en_we    = wr_en & wr_strb[LANE_EN];
  assign clr_mask = flag_we ? wr_data[N-1:0] : '0;

  irqsel_flag_bank #(.N(N)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (evt_in),
    .clr_i  (clr_mask),
    .flag_o (flags)
  );

  irqsel_enable_reg #(.N(N)) u_enables (
    .clk  (clk),
    .rst  (rst),
    .we_i (en_we),
    .d_i  (wr_data[W-1:N]),
    .en_o (enables)
  );

  irqsel_req_gen #(.N(N)) u_req (
    .clk    (clk),
    .rst    (rst),
    .flag_i (flags),
    .en_i   (enables),
    .irq_o  (irq_o)
  );

  assign rd_data = {enables, flags};

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> ((rd_data == '0) && !irq_o));

  a_r9_idle_mask: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data[W-1:N]));

  a_r9_idle_flags: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((rd_data[N-1:0] & $past(rd_data[N-1:0])) == $past(rd_data[N-1:0])));
endmodule

// File: tb/irqsel_top_tb_top.sv
module irqsel_top_tb_top;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt_in = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_strb = 2'b00;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irqsel_top #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .evt_in(evt_in), .wr_en(wr_en),
    .wr_strb(wr_strb), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
  );

  // Behavioural reference model
  logic [N-1:0] m_flag = '0;
  logic [N-1:0] m_en   = '0;
  logic         m_irq  = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_flag = '0; m_en = '0; m_irq = 1'b0;
    end else begin
      logic nxt_irq;
      nxt_irq = 1'b0;
      for (int i = 0; i < N; i++) if (m_flag[i] && m_en[i]) nxt_irq = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (evt_in[i]) m_flag[i] = 1'b1;
        else if (wr_en && wr_strb[0] && wr_data[i]) m_flag[i] = 1'b0;
      end
      if (wr_en && wr_strb[1]) m_en = wr_data[W-1:N];
      m_irq = nxt_irq;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check(rd_data[N-1:0] == m_flag, "R2", "flags vs model", rd_data[N-1:0], m_flag);
      check(rd_data[W-1:N] == m_en, "R5", "enables vs model", rd_data[W-1:N], m_en);
      check(irq_o == m_irq, "R6", "irq vs model", irq_o, m_irq);
    end
  end

  task automatic idle();
    evt_in = '0; wr_en = 1'b0; wr_strb = 2'b00; wr_data = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    wr_en = 1'b1; wr_strb = s; wr_data = d;
    cyc(1);
    idle();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    cyc(3);
    check(rd_data == '0, "R1", "word in reset", rd_data, '0);
    check(irq_o == 1'b0, "R1", "irq in reset", irq_o, 0);
    rst = 1'b0;
    cyc(1);
    check(rd_data == '0 && irq_o == 1'b0, "R1", "first cycle after reset", rd_data, '0);

    // R2 / R8: event on a masked source is latched but raises no request
    evt_in = 8'h04; cyc(1); idle();
    check(rd_data[2] == 1'b1, "R2", "masked event latched", rd_data, 16'h0004);
    cyc(3);
    check(irq_o == 1'b0, "R8", "masked flag keeps irq low", irq_o, 0);
    check(rd_data[2] == 1'b1, "R3", "flag sticky", rd_data, 16'h0004);

    // R6: enabling source 2 raises the request one edge later
    wr(2'b10, 16'h0400);
    check(rd_data == 16'h0404, "R5", "enable loaded", rd_data, 16'h0404);
    check(irq_o == 1'b0, "R6", "irq lags enable", irq_o, 0);
    cyc(1);
    check(irq_o == 1'b1, "R6", "irq asserted", irq_o, 1);

    // R3 / R5: clearing another bit leaves flag 2; upper data ignored without strobe[1]
    evt_in = 8'h10; cyc(1); idle();
    wr(2'b01, 16'hFF10);
    check(rd_data == 16'h0404, "R3", "only written flag cleared", rd_data, 16'h0404);
    check(rd_data[W-1:N] == 8'h04, "R5", "mask untouched by clear", rd_data[W-1:N], 8'h04);

    // R7: clearing the last enabled flag drops irq one edge later
    wr(2'b01, 16'h0004);
    check(rd_data == 16'h0400, "R3", "flag cleared", rd_data, 16'h0400);
    check(irq_o == 1'b1, "R7", "irq still high for one cycle", irq_o, 1);
    cyc(1);
    check(irq_o == 1'b0, "R7", "irq dropped", irq_o, 0);

    // R4: set wins over same-cycle clear
    evt_in = 8'h20; cyc(1); idle();
    evt_in = 8'h20; wr_en = 1'b1; wr_strb = 2'b01; wr_data = 16'h0020;
    cyc(1); idle();
    check(rd_data[5] == 1'b1, "R4", "set beats clear", rd_data, 16'h0420);

    // R9: strobes ignored while wr_en is low
    wr_en = 1'b0; wr_strb = 2'b11; wr_data = 16'hFFFF;
    cyc(2); idle();
    check(rd_data == 16'h0420, "R9", "no write without wr_en", rd_data, 16'h0420);

    // R7: removing the enable drops irq
    wr(2'b10, 16'h2000);
    cyc(1);
    check(irq_o == 1'b1, "R6", "enable on flagged source", irq_o, 1);
    wr(2'b10, 16'h0000);
    cyc(1);
    check(irq_o == 1'b0, "R7", "enable removed", irq_o, 0);
    wr(2'b11, 16'h00FF);
    check(rd_data == '0, "R3", "both halves written", rd_data, '0);

    // Mixed traffic, compared against the model on every cycle
    for (int k = 0; k < 3000; k++) begin
      evt_in  = ($urandom % 4 == 0) ? N'($urandom) : '0;
      wr_en   = ($urandom % 3 == 0);
      wr_strb = 2'($urandom);
      wr_data = W'($urandom);
      cyc(1);
    end
    idle();
    cyc(2);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule